// File: doc/BRIEF.md
# Inter-Core Interrupt Mailbox

This block lets the cores of a multicore processor signal one another and pass short messages. Each of eight cores (two nodes of four) owns a private register page on a 32-bit register bus. A sender raises bits in a target core's pending word by writing to that core's raise register. It can also leave data in the core's four message words. The target core takes an interrupt whenever a pending bit is unmasked. It reads the messages and writes the handled bits to its drop register.

A bus access gives a node identifier and an offset inside that node's 4 KiB window. The target core within the node comes from offset bits [9:8]. Read data and the access-error flag are registered and appear on the cycle after the request.

Top module: `ipi_mailbox_unit`

## Requirements
- R1: The target core is `node*4 + addr[9:8]`. An offset with bits [11:10] not zero decodes to nothing, so the node-1 window serves cores 4 to 7.
- R2: The mask register (page offset 0x04) and the message words (offsets 0x20, 0x28, 0x30 and 0x38 for words 0 to 3) are plain 32-bit read/write storage per core. Read data appears on `rd_data` one cycle after a read request.
- R3: The pending word (offset 0x00) is read-only. A write to it raises `acc_err` one cycle later and changes no state.
- R4: A write to the raise register (offset 0x08) ORs the written value into the target core's pending word.
- R5: A write to the drop register (offset 0x0C) clears the written bits of the target core's pending word and leaves the other bits alone.
- R6: The raise and drop registers are write-only. A read of either returns all ones and raises `acc_err` one cycle later.
- R7: A read of an undecoded offset returns all ones without an error. A write to an undecoded offset changes no state.
- R8: `irq[c]` is the OR of core c's pending word ANDed with its mask, registered once. Masked bits never assert it.
- R9: A synchronous reset clears every pending, mask and message word and deasserts every interrupt.
- R10: `acc_err` is high for exactly the one cycle after an illegal access and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Bus request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_node | input | 1 | Node whose window is addressed |
| req_addr | input | 12 | Byte offset inside the node window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read |
| acc_err | output | 1 | Illegal-access pulse, the cycle after the access |
| irq | output | 8 | One interrupt line per core |

## Verification
The hardest case to reach is a pending bit that is already set while its mask bit is clear. The line must stay low, then rise exactly one cycle after the mask is written, and fall one cycle after a partial drop removes the last unmasked bit. The stimulus raises bits on a masked core, opens the mask bit by bit, and drops subsets of bits. The behavioural model compares all eight lines on every cycle, so an early or late edge is caught. Cross-node aliasing is covered by filling every message word of all eight cores with distinct values before reading them back.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   typedef enum logic [2:0] {
      RK_NONE,
      RK_PEND,
      RK_MASK,
      RK_RAISE,
      RK_DROP,
      RK_MSG
   } reg_kind_e;

   localparam int OFF_PEND  = 'h00;
   localparam int OFF_MASK  = 'h04;
   localparam int OFF_RAISE = 'h08;
   localparam int OFF_DROP  = 'h0C;
   localparam int MSG_BASE  = 'h20;
   localparam int MSG_STEP  = 8;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
   import ipi_pkg::*;
#(
   parameter int CORES_PER_NODE = 4,
   parameter int NUM_NODES      = 2,
   parameter int WIN_AW         = 12,
   parameter int PAGE_SHIFT     = 8,
   parameter int MSG_WORDS      = 4,
   localparam int NODE_W = $clog2(NUM_NODES),
   localparam int CB     = $clog2(CORES_PER_NODE),
   localparam int CW     = NODE_W + CB,
   localparam int MW     = $clog2(MSG_WORDS)
) (
   input  logic [NODE_W-1:0] node_i,
   input  logic [WIN_AW-1:0] addr_i,
   output reg_kind_e         kind_o,
   output logic [CW-1:0]     core_o,
   output logic [MW-1:0]     msg_o
);
   localparam logic [PAGE_SHIFT-1:0] O_PEND  = PAGE_SHIFT'(OFF_PEND);
   localparam logic [PAGE_SHIFT-1:0] O_MASK  = PAGE_SHIFT'(OFF_MASK);
   localparam logic [PAGE_SHIFT-1:0] O_RAISE = PAGE_SHIFT'(OFF_RAISE);
   localparam logic [PAGE_SHIFT-1:0] O_DROP  = PAGE_SHIFT'(OFF_DROP);
   localparam logic [PAGE_SHIFT-1:0] O_MSG   = PAGE_SHIFT'(MSG_BASE);
   localparam logic [PAGE_SHIFT-1:0] MSG_SPAN = PAGE_SHIFT'(MSG_STEP * MSG_WORDS);

   logic [PAGE_SHIFT-1:0] off;
   logic [PAGE_SHIFT-1:0] rel;
   logic                  page_ok;

   assign off     = addr_i[PAGE_SHIFT-1:0];
   assign rel     = off - O_MSG;
   assign page_ok = (addr_i[WIN_AW-1:PAGE_SHIFT+CB] == '0);
   assign core_o  = {node_i, addr_i[PAGE_SHIFT +: CB]};
   assign msg_o   = rel[3 +: MW];

   always_comb begin
      kind_o = RK_NONE;
      if (page_ok) begin
         if (off == O_PEND)       kind_o = RK_PEND;
         else if (off == O_MASK)  kind_o = RK_MASK;
         else if (off == O_RAISE) kind_o = RK_RAISE;
         else if (off == O_DROP)  kind_o = RK_DROP;
         else if (off >= O_MSG && rel < MSG_SPAN && rel[2:0] == 3'd0)
            kind_o = RK_MSG;
      end
   end
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
   import ipi_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MSG_WORDS = 4,
   localparam int MW = $clog2(MSG_WORDS)
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               wr_i,
   input  reg_kind_e                          kind_i,
   input  logic [MW-1:0]                      msg_i,
   input  logic [DATA_W-1:0]                  wdata_i,
   output logic [DATA_W-1:0]                  pend_o,
   output logic [DATA_W-1:0]                  mask_o,
   output logic [MSG_WORDS-1:0][DATA_W-1:0]   msg_o,
   output logic                               irq_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         pend_o <= '0;
         mask_o <= '0;
         msg_o  <= '0;
      end else if (wr_i) begin
         case (kind_i)
            RK_MASK:  mask_o <= wdata_i;
            RK_RAISE: pend_o <= pend_o | wdata_i;
            RK_DROP:  pend_o <= pend_o & ~wdata_i;
            RK_MSG:   msg_o[msg_i] <= wdata_i;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) irq_o <= 1'b0;
      else     irq_o <= |(pend_o & mask_o);
   end

   AST_PEND_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
      (wr_i && kind_i == RK_PEND) |=> $stable(pend_o)); // R3
   AST_RAISE_BITS_LAND: assert property (@(posedge clk) disable iff (rst)
      (wr_i && kind_i == RK_RAISE) |=> ((pend_o & $past(wdata_i)) == $past(wdata_i))); // R4
   AST_DROP_BITS_GONE: assert property (@(posedge clk) disable iff (rst)
      (wr_i && kind_i == RK_DROP) |=> ((pend_o & $past(wdata_i)) == '0)); // R5
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
      ((pend_o & mask_o) == '0) |=> !irq_o); // R8
   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (|(pend_o & mask_o)) |=> irq_o); // R8
endmodule

// File: rtl/ipi_read_mux.sv
module ipi_read_mux
   import ipi_pkg::*;
#(
   parameter int NUM_CORES = 8,
   parameter int DATA_W    = 32,
   parameter int MSG_WORDS = 4,
   localparam int CW = $clog2(NUM_CORES),
   localparam int MW = $clog2(MSG_WORDS)
) (
   input  reg_kind_e                                         kind_i,
   input  logic [CW-1:0]                                     core_i,
   input  logic [MW-1:0]                                     msg_i,
   input  logic [NUM_CORES-1:0][DATA_W-1:0]                  pend_i,
   input  logic [NUM_CORES-1:0][DATA_W-1:0]                  mask_i,
   input  logic [NUM_CORES-1:0][MSG_WORDS-1:0][DATA_W-1:0]   msg_all_i,
   output logic [DATA_W-1:0]                                 rdata_o,
   output logic                                              rd_illegal_o
);
   always_comb begin
      rdata_o = '1;
      case (kind_i)
         RK_PEND: rdata_o = pend_i[core_i];
         RK_MASK: rdata_o = mask_i[core_i];
         RK_MSG:  rdata_o = msg_all_i[core_i][msg_i];
         default: rdata_o = '1;
      endcase
   end

   assign rd_illegal_o = (kind_i == RK_RAISE) || (kind_i == RK_DROP);
endmodule

// File: rtl/ipi_mailbox_unit.sv
module ipi_mailbox_unit
   import ipi_pkg::*;
#(
   parameter int CORES_PER_NODE = 4,
   parameter int NUM_NODES      = 2,
   parameter int DATA_W         = 32,
   parameter int MSG_WORDS      = 4,
   parameter int WIN_AW         = 12,
   parameter int PAGE_SHIFT     = 8,
   localparam int NUM_CORES = CORES_PER_NODE * NUM_NODES,
   localparam int NODE_W    = $clog2(NUM_NODES),
   localparam int CW        = $clog2(NUM_CORES),
   localparam int MW        = $clog2(MSG_WORDS)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  req_valid,
   input  logic                  req_we,
   input  logic [NODE_W-1:0]     req_node,
   input  logic [WIN_AW-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  acc_err,
   output logic [NUM_CORES-1:0]  irq
);
   initial begin
      assert (NUM_NODES >= 2 && (NUM_NODES & (NUM_NODES - 1)) == 0)
         else $error("NUM_NODES must be a power of two, at least 2");
      assert (CORES_PER_NODE >= 2 && (CORES_PER_NODE & (CORES_PER_NODE - 1)) == 0)
         else $error("CORES_PER_NODE must be a power of two, at least 2");
      assert (MSG_WORDS >= 2 && (MSG_WORDS & (MSG_WORDS - 1)) == 0)
         else $error("MSG_WORDS must be a power of two, at least 2");
      assert (MSG_BASE + MSG_STEP * MSG_WORDS <= (1 << PAGE_SHIFT))
         else $error("message words overflow the core page");
      assert (PAGE_SHIFT + $clog2(CORES_PER_NODE) < WIN_AW)
         else $error("core pages overflow the node window");
   end

   reg_kind_e       kind;
   logic [CW-1:0]   core;
   logic [MW-1:0]   msg_idx;
   logic [DATA_W-1:0] mux_data;
   logic            rd_illegal;

   logic [NUM_CORES-1:0][DATA_W-1:0]                pend_all;
   logic [NUM_CORES-1:0][DATA_W-1:0]                mask_all;
   logic [NUM_CORES-1:0][MSG_WORDS-1:0][DATA_W-1:0] msg_all;

   ipi_addr_decode #(
      .CORES_PER_NODE(CORES_PER_NODE), .NUM_NODES(NUM_NODES),
      .WIN_AW(WIN_AW), .PAGE_SHIFT(PAGE_SHIFT), .MSG_WORDS(MSG_WORDS)
   ) u_dec (
      .node_i(req_node), .addr_i(req_addr),
      .kind_o(kind), .core_o(core), .msg_o(msg_idx)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic wr_here;
      assign wr_here = req_valid && req_we && (core == CW'(c)) && (kind != RK_NONE);
      ipi_core_slot #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)) u_slot (
         .clk(clk), .rst(rst), .wr_i(wr_here), .kind_i(kind),
         .msg_i(msg_idx), .wdata_i(req_wdata),
         .pend_o(pend_all[c]), .mask_o(mask_all[c]),
         .msg_o(msg_all[c]), .irq_o(irq[c])
      );
   end

   ipi_read_mux #(
      .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)
   ) u_rmux (
      .kind_i(kind), .core_i(core), .msg_i(msg_idx),
      .pend_i(pend_all), .mask_i(mask_all), .msg_all_i(msg_all),
      .rdata_o(mux_data), .rd_illegal_o(rd_illegal)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data <= '0;
         acc_err <= 1'b0;
      end else begin
         acc_err <= req_valid && (req_we ? (kind == RK_PEND) : rd_illegal);
         if (req_valid && !req_we) rd_data <= mux_data;
      end
   end

   AST_ERR_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !acc_err); // R10
   AST_ERR_PEND_WRITE: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_we && kind == RK_PEND) |=> acc_err); // R3
   AST_ERR_WO_READ: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_we && (kind == RK_RAISE || kind == RK_DROP)) |=> (acc_err && rd_data == '1)); // R6
   AST_UNDECODED_READ: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_we && kind == RK_NONE) |=> (!acc_err && rd_data == '1)); // R7
endmodule

// File: tb/ipi_mailbox_unit_tb.sv
`timescale 1ns/1ps
module ipi_mailbox_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [0:0]  req_node = '0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rd_data;
   logic        acc_err;
   logic [7:0]  irq;

   always #2.5 clk = ~clk;

   ipi_mailbox_unit dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
      .req_node(req_node), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_data(rd_data), .acc_err(acc_err), .irq(irq)
   );

   int errors = 0;
   int checks = 0;
   bit chk_on = 1'b0;
   string cur_tag = "R2";

   // behavioural reference state
   logic [31:0] m_pend [8];
   logic [31:0] m_mask [8];
   logic [31:0] m_msg  [8][4];
   logic [7:0]  exp_irq = '0;
   logic        exp_err = 1'b0;
   logic        exp_rv  = 1'b0;
   logic [31:0] exp_rdata = '0;
   string       exp_tag = "R2";

   always @(posedge clk) begin
      if (rst) begin
         for (int c = 0; c < 8; c++) begin
            m_pend[c] = 0; m_mask[c] = 0;
            for (int w = 0; w < 4; w++) m_msg[c][w] = 0;
         end
         exp_irq = 0; exp_err = 0; exp_rv = 0;
      end else begin
         for (int c = 0; c < 8; c++) exp_irq[c] = |(m_pend[c] & m_mask[c]);
         exp_err = 0; exp_rv = 0;
         exp_tag = cur_tag;
         if (req_valid) begin
            int core;
            int off;
            bit hit;
            core = req_node * 4 + req_addr[9:8];
            off  = req_addr[7:0];
            hit  = (req_addr[11:10] == 2'b00);
            if (req_we) begin
               if (hit) begin
                  if (off == 0) exp_err = 1;
                  else if (off == 4) m_mask[core] = req_wdata;
                  else if (off == 8) m_pend[core] = m_pend[core] | req_wdata;
                  else if (off == 12) m_pend[core] = m_pend[core] & ~req_wdata;
                  else if (off == 'h20 || off == 'h28 || off == 'h30 || off == 'h38)
                     m_msg[core][(off - 'h20) / 8] = req_wdata;
               end
            end else begin
               exp_rv = 1;
               exp_rdata = 32'hFFFF_FFFF;
               if (hit) begin
                  if (off == 0) exp_rdata = m_pend[core];
                  else if (off == 4) exp_rdata = m_mask[core];
                  else if (off == 8 || off == 12) exp_err = 1;
                  else if (off == 'h20 || off == 'h28 || off == 'h30 || off == 'h38)
                     exp_rdata = m_msg[core][(off - 'h20) / 8];
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (chk_on) begin
         checks++;
         if (irq !== exp_irq) begin
            errors++;
            $display("FAIL R8 irq: actual=%b expected=%b at %0t", irq, exp_irq, $time);
         end
         checks++;
         if (acc_err !== exp_err) begin
            errors++;
            $display("FAIL %s/R10 acc_err: actual=%b expected=%b at %0t", exp_tag, acc_err, exp_err, $time);
         end
         if (exp_rv) begin
            checks++;
            if (rd_data !== exp_rdata) begin
               errors++;
               $display("FAIL %s rd_data: actual=%h expected=%h at %0t", exp_tag, rd_data, exp_rdata, $time);
            end
         end
      end
   end

   task automatic bus(input bit we, input bit node, input logic [11:0] a,
                      input logic [31:0] d, input string tag);
      @(negedge clk);
      cur_tag = tag;
      req_valid = 1; req_we = we; req_node = node; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0; req_we = 0;
   endtask

   task automatic wr(input bit node, input logic [11:0] a, input logic [31:0] d, input string tag);
      bus(1'b1, node, a, d, tag);
   endtask

   task automatic rd(input bit node, input logic [11:0] a, input string tag);
      bus(1'b0, node, a, 32'h0, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic fill_all;
      for (int c = 0; c < 8; c++)
         for (int w = 0; w < 4; w++)
            wr(c / 4, 12'((c % 4) * 'h100 + 'h20 + w * 8), 32'hA500_0000 | (c << 8) | w, "R1");
   endtask

   task automatic check_quiet(input string tag);
      checks++;
      if (irq !== 8'h00) begin
         errors++;
         $display("FAIL %s irq after reset: actual=%h expected=00", tag, irq);
      end
   endtask

   initial begin
      idle(3);
      @(negedge clk) rst = 0;
      chk_on = 1;
      check_quiet("R9");
      // R9: reset contents are zero
      rd(0, 12'h000, "R9"); rd(1, 12'h304, "R9"); rd(1, 12'h238, "R9");
      // R2: mask and message storage
      wr(0, 12'h204, 32'hFFFF_0000, "R2"); rd(0, 12'h204, "R2");
      wr(0, 12'h028, 32'h1234_5678, "R2"); rd(0, 12'h028, "R2");
      // R1: every core, every message word, distinct values
      fill_all();
      for (int c = 0; c < 8; c++)
         for (int w = 0; w < 4; w++)
            rd(c / 4, 12'((c % 4) * 'h100 + 'h20 + w * 8), "R1");
      // R4 / R8: raise on an unmasked core, then on a masked core
      wr(1, 12'h104, 32'h0000_0001, "R8");
      wr(1, 12'h108, 32'h0001_0001, "R4"); idle(2); rd(1, 12'h100, "R4");
      wr(0, 12'h308, 32'h0000_00F0, "R8"); idle(3); rd(0, 12'h300, "R4");
      // R8: open the mask on the masked core bit by bit
      wr(0, 12'h304, 32'h0000_000F, "R8"); idle(2);
      wr(0, 12'h304, 32'h0000_0010, "R8"); idle(2);
      // R5: partial drop keeps others; drop last unmasked bit
      wr(0, 12'h30C, 32'h0000_0030, "R5"); rd(0, 12'h300, "R5"); idle(1);
      wr(0, 12'h30C, 32'h0000_0010, "R5"); idle(2); rd(0, 12'h300, "R5");
      wr(1, 12'h10C, 32'h0000_0001, "R5"); idle(2); rd(1, 12'h100, "R5");
      // R3: write to pending word is illegal and harmless
      wr(1, 12'h100, 32'hFFFF_FFFF, "R3"); idle(1); rd(1, 12'h100, "R3");
      // R6: reads of write-only registers
      rd(0, 12'h008, "R6"); rd(1, 12'h30C, "R6"); idle(1);
      // R7: undecoded reads and writes
      rd(0, 12'h010, "R7"); rd(0, 12'h024, "R7"); rd(1, 12'h400, "R7"); rd(0, 12'h022, "R7");
      wr(0, 12'h024, 32'hDEAD_BEEF, "R7"); wr(0, 12'h420, 32'hDEAD_BEEF, "R7");
      wr(1, 12'hC08, 32'hFFFF_FFFF, "R7"); idle(2);
      rd(0, 12'h020, "R7"); rd(0, 12'h028, "R7"); rd(0, 12'h000, "R7");
      // R10: back-to-back illegal then legal accesses
      wr(0, 12'h000, 32'h1, "R10"); rd(0, 12'h004, "R10"); rd(0, 12'h00C, "R10"); idle(2);
      // R9: reset with state present
      wr(1, 12'h304, 32'hFFFF_FFFF, "R9"); wr(1, 12'h308, 32'h8000_0000, "R9"); idle(2);
      @(negedge clk) rst = 1;
      idle(2);
      @(negedge clk) rst = 0;
      check_quiet("R9");
      rd(1, 12'h300, "R9"); rd(1, 12'h304, "R9"); rd(0, 12'h020, "R9");
      idle(3);
      chk_on = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule